// File: doc/BRIEF.md
# CAN Fault Confinement Status Unit

This block keeps the fault-confinement state of one CAN controller. It holds a transmit error counter and a receive error counter and derives three level flags from them: a warning flag, an error-passive flag and a bus-off flag. It also holds a 3-bit code naming the most recent bus error. All of this is presented as one 32-bit status word.

The protocol engine drives single-cycle pulses into the block. One pulse reports a detected error, together with its type and with whether the node was the transmitter. Other pulses report a successful transmit, a successful receive, and a completed bus-off recovery. Software reaches only the error-code field, through a simple write strobe and data word.

The software path has one intended use. Software writes code 7, which hardware never produces. A later change of the field then shows that hardware has recorded a new error or a successful frame.

Top module: `can_fc_status`

## Requirements
- R1: After reset the whole status word reads 0.
- R2: A transmit-side error adds 8 to the transmit count shown in bits 23:16. A successful transmit subtracts 1 from it, and the count never goes below 0.
- R3: A receive-side error adds 1 to the receive count shown in bits 31:24, and the count saturates at 255. A successful receive subtracts 1 from it, and the count never goes below 0.
- R4: When an error and a success pulse hit the same counter in one cycle, the error step is applied and the success pulse is dropped.
- R5: Bit 0 (warning) reads 1 whenever either count is 96 or more.
- R6: Bit 1 (error passive) reads 1 whenever either count is above 127.
- R7: Bit 2 (bus-off) reads 1 once the internal transmit count exceeds 255. While bus-off, bits 23:16 read 255.
- R8: While bus-off, error and success pulses leave both counters unchanged.
- R9: A recovery pulse clears both counters, and with them every flag, by the next cycle.
- R10: On a detected error, bits 6:4 load the error's code: 1 stuffing, 2 form, 3 acknowledge, 4 recessive-bit, 5 dominant-bit, 6 CRC. Code 7 is left to software.
- R11: A successful transmit or receive returns bits 6:4 to 0.
- R12: When the write strobe is high, bits 6:4 take bits 6:4 of the write data and every other written bit is ignored. Bits 15:7 and bit 3 always read 0.
- R13: Within one cycle, a hardware error code takes priority over a success clear, and a success clear takes priority over a software write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| err_vld_i | input | 1 | Pulse: a bus error was detected |
| err_code_i | input | 3 | Type code of the detected error (1 to 6) |
| err_is_tx_i | input | 1 | The detected error occurred while the node was transmitting |
| tx_ok_i | input | 1 | Pulse: a frame was transmitted successfully |
| rx_ok_i | input | 1 | Pulse: a frame was received successfully |
| recover_i | input | 1 | Pulse: bus-off recovery is complete |
| wr_en_i | input | 1 | Software write strobe for the status word |
| wr_data_i | input | 32 | Software write data; only bits 6:4 are used |
| status_o | output | 32 | Packed status word |

## Verification
The assertions assume two things about the inputs. An error pulse always carries a hardware code from 1 to 6, never 0 or 7. Each event pulse lasts a single cycle, so one pulse counts as exactly one event. The directed and random stimulus draw every error code from the range 1 to 6 and drive every pulse for one step only. Events and the recovery pulse may still coincide within a cycle, because the priority rules decide those cases.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;

   typedef enum logic [2:0] {
      ERR_NONE    = 3'd0,
      ERR_STUFF   = 3'd1,
      ERR_FORM    = 3'd2,
      ERR_ACK     = 3'd3,
      ERR_BIT_REC = 3'd4,
      ERR_BIT_DOM = 3'd5,
      ERR_CRC     = 3'd6,
      ERR_SW_MARK = 3'd7
   } can_err_e;

   localparam int unsigned STAT_W    = 32;
   localparam int unsigned RXC_LSB   = 24;
   localparam int unsigned TXC_LSB   = 16;
   localparam int unsigned CODE_LSB  = 4;
   localparam int unsigned BOFF_BIT  = 2;
   localparam int unsigned PASS_BIT  = 1;
   localparam int unsigned WARN_BIT  = 0;

endpackage

// File: rtl/can_fc_errctr.sv
module can_fc_errctr #(
   parameter int unsigned CNT_W   = 8,
   parameter int unsigned STEP    = 1,
   parameter bit          OVF_BIT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             hold_i,
   input  logic             err_i,
   input  logic             ok_i,
   output logic [CNT_W:0]   cnt_o
);

   localparam int unsigned  FULL_W = CNT_W + 1;
   localparam logic [FULL_W:0]   MAX_V  = (FULL_W+1)'((2**CNT_W) - 1);
   localparam logic [FULL_W:0]   STEP_V = (FULL_W+1)'(STEP);
   localparam logic [FULL_W-1:0] ONE_V  = FULL_W'(1);

   if (STEP < 1 || STEP > (2**CNT_W)) begin : g_bad_step
      $error("can_fc_errctr: STEP out of range");
   end

   logic [FULL_W-1:0] cnt_q, cnt_d, inc_v;
   logic [FULL_W:0]   sum_v;

   assign sum_v = {1'b0, cnt_q} + STEP_V;

   if (OVF_BIT) begin : g_ovf
      assign inc_v = sum_v[FULL_W-1:0];
   end else begin : g_sat
      assign inc_v = (sum_v > MAX_V) ? MAX_V[FULL_W-1:0] : sum_v[FULL_W-1:0];
   end

   always_comb begin
      cnt_d = cnt_q;
      if (clr_i) begin
         cnt_d = '0;
      end else if (!hold_i) begin
         if (err_i) begin
            cnt_d = inc_v;
         end else if (ok_i && cnt_q != '0) begin
            cnt_d = cnt_q - ONE_V;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign cnt_o = cnt_q;

   AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> cnt_q == '0); // R9

   AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_i && !clr_i) |=> $stable(cnt_q)); // R8

   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (ok_i && !err_i && !hold_i && !clr_i && cnt_q == '0) |=> cnt_q == '0); // R2

   AST_ERR_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      (err_i && !hold_i && !clr_i && {1'b0, cnt_q} < MAX_V) |=> cnt_q > $past(cnt_q)); // R4

   if (!OVF_BIT) begin : g_sat_chk
      AST_SAT_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
         {1'b0, cnt_q} <= MAX_V); // R3
   end

endmodule

// File: rtl/can_fc_codereg.sv
module can_fc_codereg #(
   parameter int unsigned CODE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hw_vld_i,
   input  logic [CODE_W-1:0] hw_code_i,
   input  logic              clr_i,
   input  logic              sw_we_i,
   input  logic [CODE_W-1:0] sw_code_i,
   output logic [CODE_W-1:0] code_o
);

   localparam logic [CODE_W-1:0] SW_MARK = {CODE_W{1'b1}};

   logic [CODE_W-1:0] code_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          code_q <= '0;
      else if (hw_vld_i)   code_q <= hw_code_i;
      else if (clr_i)      code_q <= '0;
      else if (sw_we_i)    code_q <= sw_code_i;
   end

   assign code_o = code_q;

   AST_HW_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      hw_vld_i |-> (hw_code_i != '0 && hw_code_i != SW_MARK)); // R10

   AST_HW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      hw_vld_i |=> code_q == $past(hw_code_i)); // R10

   AST_OK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !hw_vld_i) |=> code_q == '0); // R11

   AST_SW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_we_i && !hw_vld_i && !clr_i) |=> code_q == $past(sw_code_i)); // R12

   AST_IDLE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_we_i && !hw_vld_i && !clr_i) |=> $stable(code_q)); // R13

endmodule

// File: rtl/can_fc_status.sv
module can_fc_status
   import can_fc_pkg::*;
#(
   parameter int unsigned CNT_W         = 8,
   parameter int unsigned CODE_W        = 3,
   parameter int unsigned TX_ERR_STEP   = 8,
   parameter int unsigned RX_ERR_STEP   = 1,
   parameter int unsigned WARN_LIMIT    = 96,
   parameter int unsigned PASSIVE_LIMIT = 127
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              err_vld_i,
   input  logic [2:0]        err_code_i,
   input  logic              err_is_tx_i,
   input  logic              tx_ok_i,
   input  logic              rx_ok_i,
   input  logic              recover_i,
   input  logic              wr_en_i,
   input  logic [31:0]       wr_data_i,
   output logic [31:0]       status_o
);

   localparam logic [CNT_W:0] WARN_V = (CNT_W+1)'(WARN_LIMIT);
   localparam logic [CNT_W:0] PASS_V = (CNT_W+1)'(PASSIVE_LIMIT);

   if (CNT_W != 8 || CODE_W != 3) begin : g_bad_layout
      $error("can_fc_status: field widths must match the 32-bit word layout");
   end
   if (WARN_LIMIT > PASSIVE_LIMIT || PASSIVE_LIMIT >= (2**CNT_W)) begin : g_bad_limits
      $error("can_fc_status: threshold ordering violated");
   end

   logic [CNT_W:0]    tx_cnt, rx_cnt;
   logic [CNT_W-1:0]  tx_vis;
   logic [CODE_W-1:0] code;
   logic              busoff, passive, warn;

   assign busoff = tx_cnt[CNT_W];

   can_fc_errctr #(.CNT_W(CNT_W), .STEP(TX_ERR_STEP), .OVF_BIT(1'b1)) u_txctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (recover_i),
      .hold_i (busoff),
      .err_i  (err_vld_i & err_is_tx_i),
      .ok_i   (tx_ok_i),
      .cnt_o  (tx_cnt)
   );

   can_fc_errctr #(.CNT_W(CNT_W), .STEP(RX_ERR_STEP), .OVF_BIT(1'b0)) u_rxctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (recover_i),
      .hold_i (busoff),
      .err_i  (err_vld_i & ~err_is_tx_i),
      .ok_i   (rx_ok_i),
      .cnt_o  (rx_cnt)
   );

   can_fc_codereg #(.CODE_W(CODE_W)) u_code (
      .clk       (clk),
      .rst_n     (rst_n),
      .hw_vld_i  (err_vld_i),
      .hw_code_i (err_code_i[CODE_W-1:0]),
      .clr_i     (tx_ok_i | rx_ok_i),
      .sw_we_i   (wr_en_i),
      .sw_code_i (wr_data_i[CODE_LSB +: CODE_W]),
      .code_o    (code)
   );

   assign tx_vis  = busoff ? {CNT_W{1'b1}} : tx_cnt[CNT_W-1:0];
   assign warn    = (tx_cnt >= WARN_V) || (rx_cnt >= WARN_V);
   assign passive = (tx_cnt > PASS_V) || (rx_cnt > PASS_V);

   always_comb begin
      status_o = '0;
      status_o[RXC_LSB +: CNT_W]  = rx_cnt[CNT_W-1:0];
      status_o[TXC_LSB +: CNT_W]  = tx_vis;
      status_o[CODE_LSB +: CODE_W] = code;
      status_o[BOFF_BIT] = busoff;
      status_o[PASS_BIT] = passive;
      status_o[WARN_BIT] = warn;
   end

   AST_PASSIVE_HAS_WARN: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[PASS_BIT] |-> status_o[WARN_BIT]); // R6

   AST_BUSOFF_HAS_PASSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[BOFF_BIT] |-> status_o[PASS_BIT]); // R7

   AST_BUSOFF_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busoff) |-> $past(err_vld_i && err_is_tx_i)); // R7

endmodule

// File: tb/can_fc_status_tb.sv
module can_fc_status_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        err_vld = 1'b0;
   logic [2:0]  err_code = 3'd0;
   logic        err_tx = 1'b0;
   logic        tx_ok = 1'b0;
   logic        rx_ok = 1'b0;
   logic        recover = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] status;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   int m_tx = 0;
   int m_rx = 0;
   int m_code = 0;

   always #2 clk = ~clk;

   can_fc_status dut_i (
      .clk(clk), .rst_n(rst_n),
      .err_vld_i(err_vld), .err_code_i(err_code), .err_is_tx_i(err_tx),
      .tx_ok_i(tx_ok), .rx_ok_i(rx_ok), .recover_i(recover),
      .wr_en_i(wr_en), .wr_data_i(wr_data),
      .status_o(status)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      int tvis;
      tvis = (m_tx > 255) ? 255 : m_tx;
      chk("R3 rx count", int'(status[31:24]), m_rx);
      chk("R2 tx count", int'(status[23:16]), tvis);
      chk("R12 reserved 15:7", int'(status[15:7]), 0);
      chk("R12 reserved 3", int'(status[3]), 0);
      chk("R10 error code", int'(status[6:4]), m_code);
      chk("R7 bus-off", int'(status[2]), int'(m_tx > 255));
      chk("R6 passive", int'(status[1]), int'(m_tx > 127 || m_rx > 127));
      chk("R5 warning", int'(status[0]), int'(m_tx >= 96 || m_rx >= 96));
   endtask

   task automatic step(input bit e, input int c, input bit t, input bit tok,
                       input bit rok, input bit rec, input bit we, input logic [31:0] wd);
      err_vld = e; err_code = 3'(c); err_tx = t; tx_ok = tok; rx_ok = rok;
      recover = rec; wr_en = we; wr_data = wd;
      @(posedge clk);
      if (rec) begin
         m_tx = 0; m_rx = 0;
      end else if (m_tx <= 255) begin
         if (e && t) m_tx += 8;
         else if (tok && m_tx > 0) m_tx--;
         if (e && !t) m_rx = (m_rx < 255) ? m_rx + 1 : 255;
         else if (rok && m_rx > 0) m_rx--;
      end
      if (e) m_code = c;
      else if (tok || rok) m_code = 0;
      else if (we) m_code = int'(wd[6:4]);
      #1;
      err_vld = 0; tx_ok = 0; rx_ok = 0; recover = 0; wr_en = 0;
      compare_all();
   endtask

   task automatic idle();
      step(0, 0, 0, 0, 0, 0, 0, '0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R1 watchdog: actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      chk("R1 reset word", int'(status == 32'd0), 1);
      idle();

      // R2, R5, R6: transmit errors walk through the thresholds
      for (int i = 0; i < 12; i++) step(1, 1 + (i % 6), 1, 0, 0, 0, 0, '0);
      chk("R5 warn at tx 96", int'(status[0]), 1);
      for (int i = 0; i < 4; i++) step(1, 2, 1, 0, 0, 0, 0, '0);
      chk("R6 passive at tx 128", int'(status[1]), 1);
      // R2: decrement to zero and past it
      for (int i = 0; i < 132; i++) step(0, 0, 0, 1, 0, 0, 0, '0);
      chk("R2 tx floor", int'(status[23:16]), 0);

      // R3: receive errors up to saturation, then back down
      for (int i = 0; i < 270; i++) step(1, 6, 0, 0, 0, 0, 0, '0);
      chk("R3 rx saturate", int'(status[31:24]), 255);
      for (int i = 0; i < 258; i++) step(0, 0, 0, 0, 1, 0, 0, '0);
      chk("R3 rx floor", int'(status[31:24]), 0);

      // R4: error and success on the same counter in one cycle
      step(1, 3, 1, 1, 0, 0, 0, '0);
      chk("R4 tx error wins", int'(status[23:16]), 8);
      step(1, 4, 0, 0, 1, 0, 0, '0);
      chk("R4 rx error wins", int'(status[31:24]), 1);

      // R7, R8: enter bus-off, then pulses have no effect on counters
      for (int i = 0; i < 31; i++) step(1, 5, 1, 0, 0, 0, 0, '0);
      chk("R7 bus-off set", int'(status[2]), 1);
      chk("R7 tx field saturates", int'(status[23:16]), 255);
      step(1, 1, 1, 0, 0, 0, 0, '0);
      step(1, 1, 0, 0, 0, 0, 0, '0);
      step(0, 0, 0, 1, 1, 0, 0, '0);
      chk("R8 rx frozen", int'(status[31:24]), 1);
      // R9: recovery clears everything
      step(0, 0, 0, 0, 0, 1, 0, '0);
      chk("R9 counters cleared", int'(status[31:16]), 0);
      chk("R9 flags cleared", int'(status[2:0]), 0);

      // R10 to R13: error code field
      step(0, 0, 0, 0, 0, 0, 1, 32'hFFFF_FFFF);
      chk("R12 sw writes 7", int'(status[6:4]), 7);
      idle();
      chk("R12 sw value held", int'(status[6:4]), 7);
      step(1, 3, 0, 0, 0, 0, 0, '0);
      chk("R10 hw overwrites", int'(status[6:4]), 3);
      step(0, 0, 0, 1, 0, 0, 0, '0);
      chk("R11 tx ok clears", int'(status[6:4]), 0);
      step(1, 2, 0, 0, 0, 0, 0, '0);
      step(0, 0, 0, 0, 1, 0, 0, '0);
      chk("R11 rx ok clears", int'(status[6:4]), 0);
      step(1, 6, 1, 0, 0, 0, 1, 32'h0000_0070);
      chk("R13 hw beats sw", int'(status[6:4]), 6);
      step(0, 0, 0, 0, 1, 0, 1, 32'h0000_0070);
      chk("R13 clear beats sw", int'(status[6:4]), 0);
      step(1, 4, 1, 1, 1, 0, 0, '0);
      chk("R13 hw beats clear", int'(status[6:4]), 4);
      step(0, 0, 0, 0, 0, 1, 0, '0);

      // mixed random traffic, compared every cycle against the model
      for (int i = 0; i < 4000; i++) begin
         automatic int r = int'($urandom_range(0, 99));
         automatic bit e = (r < 45);
         automatic bit t = ($urandom_range(0, 2) == 0);
         automatic bit tok = ($urandom_range(0, 3) == 0);
         automatic bit rok = ($urandom_range(0, 3) == 0);
         automatic bit rec = ($urandom_range(0, 149) == 0);
         automatic bit we = ($urandom_range(0, 9) == 0);
         step(e, int'($urandom_range(1, 6)), t, tok, rok, rec, we, $urandom);
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule